// File: doc/BRIEF.md
# Sync-Gated Receive Bit FIFO

This block stores recovered receive bits in a 48-entry, one-bit-wide FIFO. Each data bit arrives with a single-cycle bit strobe. A two-bit start selector sets when bits may be written:
- while a valid-data input is high,
- after a 16-bit sync pattern has been seen in the incoming stream, or
- on every strobe.

A host drains the FIFO one bit per read strobe. It watches a fill count, a level interrupt with a six-bit threshold, an empty flag and a sticky overflow flag.

Filling is controlled by two enables. A FIFO enable turns the FIFO on, and clearing it zeroes the fill count. A fill-arm input allows writes. Dropping the arm and then raising it again empties the FIFO and restarts the search for the sync pattern. Once the pattern has matched, every later strobed bit is stored until the arm is dropped. The bits of the pattern itself are never stored.

Top module: `rx_bit_fifo`

## Requirements
- R1: After reset the fill count is 0, the empty flag is 1 and the overflow flag is 0.
- R2: Bits leave in the order they arrived. `rd_bit` always shows the oldest stored bit. Each read strobe removes that bit and lowers the count by one in the next cycle.
- R3: The FIFO holds at most 48 bits. A write strobe that arrives while 48 bits are stored, with no read in the same cycle, loses its bit and sets the overflow flag. The overflow flag stays set until a `stat_rd` pulse clears it.
- R4: With start select 2'b00, a strobed bit is written only when `vdi_in` is high in the same cycle.
- R5: With start select 2'b01 or 2'b10, no bit is written until the pattern 16'h2DD4 has arrived, most significant bit first. The first bit stored is the one after the last pattern bit. After the match, every strobed bit is written.
- R6: With start select 2'b11, every strobed bit is written.
- R7: `lvl_irq` is high whenever the fill count is greater than or equal to the threshold {`lvl_hi`,`lvl_lo`}. It follows the count in the same cycle, so a threshold of 1 reports that data is available.
- R8: While `fill_arm` is low, no bit is written. When `fill_arm` goes from low to high, the FIFO is emptied and the sync search starts over.
- R9: While `fifo_on` is low, the fill count is held at 0 and no bit is written.
- R10: The empty flag is high exactly when the count is 0. A read strobe while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered data bit |
| bit_stb | input | 1 | One-cycle strobe marking a valid `bit_in` |
| vdi_in | input | 1 | Valid-data indication |
| fifo_on | input | 1 | FIFO mode enable; low clears the count |
| fill_arm | input | 1 | Fill enable; a rising edge restarts the FIFO |
| start_sel | input | 2 | Fill start condition select |
| lvl_lo | input | 4 | Threshold, low field |
| lvl_hi | input | 2 | Threshold, upper bits |
| rd_stb | input | 1 | Serial read strobe, removes one bit |
| stat_rd | input | 1 | Status read pulse, clears overflow |
| rd_bit | output | 1 | Oldest stored bit |
| fill_cnt | output | 6 | Number of stored bits |
| lvl_irq | output | 1 | Level interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |
| empty_flag | output | 1 | FIFO empty |

## Verification
Each strobe, read, arm edge or enable change is registered on one clock edge. Its effect on the count, the flags and `rd_bit` is therefore visible right after that edge, and the level and empty flags follow the count with no further delay. A sync match is recorded on the edge of the strobe that carries the last pattern bit, so the next strobed bit is the first one stored. The bench drives every input on the falling edge and samples on the following falling edge, half a cycle after the edge that responds.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
    localparam int DEPTH     = 48;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int LO_W      = 4;
    localparam int HI_W      = CNT_W - LO_W;
    localparam int SYNC_W    = 16;
    localparam logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4;

    typedef enum logic [1:0] {
        START_VDI    = 2'b00,
        START_SYNC_A = 2'b01,
        START_SYNC_B = 2'b10,
        START_ALWAYS = 2'b11
    } start_sel_e;

    typedef struct packed {
        logic wr;
        logic wbit;
        logic rd;
        logic clr;
    } fifo_op_t;

    function automatic logic start_ok(start_sel_e sel, logic vdi, logic hit);
        case (sel)
            START_VDI:    return vdi;
            START_SYNC_A,
            START_SYNC_B: return hit;
            default:      return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/rbf_sync_corr.sv
module rbf_sync_corr #(
    parameter int W = rbf_pkg::SYNC_W,
    parameter logic [W-1:0] PATTERN = rbf_pkg::SYNC_WORD
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic shift_en,
    input  logic bit_in,
    output logic hit
);
    logic [W-1:0] sh;
    logic [W-1:0] sh_next;

    assign sh_next = {sh[W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh  <= '0;
            hit <= 1'b0;
        end else if (shift_en && !hit) begin
            sh <= sh_next;
            if (sh_next == PATTERN) hit <= 1'b1;
        end
    end

    // R5: a match is held until the search is cleared
    p_hit_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr) |=> hit);
    // R8: clearing the search drops the match
    p_clr_drops_hit_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !hit);
endmodule

// File: rtl/rbf_fill_gate.sv
module rbf_fill_gate
    import rbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_on,
    input  logic       fill_arm,
    input  logic [1:0] start_sel,
    input  logic       vdi_in,
    input  logic       hit,
    input  logic       bit_stb,
    input  logic       bit_in,
    input  logic       rd_stb,
    output logic       sync_clr,
    output logic       sync_shift,
    output fifo_op_t   op
);
    logic arm_q;
    logic restart;

    always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= fill_arm;
    end

    assign restart    = fill_arm && !arm_q;
    assign sync_clr   = !fill_arm || !fifo_on;
    assign sync_shift = bit_stb && fifo_on && fill_arm;

    always_comb begin
        op.wr   = bit_stb && fifo_on && fill_arm
                  && start_ok(start_sel_e'(start_sel), vdi_in, hit);
        op.wbit = bit_in;
        op.rd   = rd_stb && fifo_on;
        op.clr  = !fifo_on || restart;
    end

    // R8: a rising arm always produces a clear in that cycle
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_arm && !arm_q) |-> op.clr);
endmodule

// File: rtl/rbf_bit_store.sv
module rbf_bit_store
    import rbf_pkg::*;
#(
    parameter int D  = DEPTH,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_op_t      op,
    input  logic          ovf_clr,
    output logic          head_bit,
    output logic [CW-1:0] cnt,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL = CW'(D);

    logic [D-1:0]  mem;
    logic [D-1:0]  mem_nx;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] wpos;
    logic          do_rd;
    logic          do_wr;
    logic          drop;

    always_comb begin
        do_rd  = op.rd && (cnt != '0);
        do_wr  = op.wr && ((cnt != FULL) || do_rd);
        drop   = op.wr && (cnt == FULL) && !do_rd;
        mem_nx = do_rd ? (mem >> 1) : mem;
        wpos   = do_rd ? (cnt - CW'(1)) : cnt;
        if (do_wr) mem_nx[wpos] = op.wbit;
        cnt_nx = cnt + CW'(do_wr) - CW'(do_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (op.clr) begin
                cnt <= '0;
            end else begin
                mem <= mem_nx;
                cnt <= cnt_nx;
            end
            if (drop && !op.clr) ovf <= 1'b1;
            else if (ovf_clr)    ovf <= 1'b0;
        end
    end

    assign head_bit = mem[0];

    // R3: count never exceeds the depth
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
    // R3: overflow is sticky until a status read
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
    // R3: write into a full FIFO keeps the count and flags overflow
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && op.wr && !op.rd && !op.clr) |=> (cnt == FULL && ovf));
    // R10: reading an empty FIFO leaves it empty
    p_rd_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && op.rd && !op.wr) |=> cnt == '0);
endmodule

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             bit_stb,
    input  logic             vdi_in,
    input  logic             fifo_on,
    input  logic             fill_arm,
    input  logic [1:0]       start_sel,
    input  logic [LO_W-1:0]  lvl_lo,
    input  logic [HI_W-1:0]  lvl_hi,
    input  logic             rd_stb,
    input  logic             stat_rd,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill_cnt,
    output logic             lvl_irq,
    output logic             ovf_flag,
    output logic             empty_flag
);
    logic     hit;
    logic     sync_clr;
    logic     sync_shift;
    fifo_op_t op;

    rbf_sync_corr #(.W(SYNC_W), .PATTERN(SYNC_WORD)) u_corr (
        .clk(clk), .rst(rst), .clr(sync_clr), .shift_en(sync_shift),
        .bit_in(bit_in), .hit(hit)
    );

    rbf_fill_gate u_gate (
        .clk(clk), .rst(rst), .fifo_on(fifo_on), .fill_arm(fill_arm),
        .start_sel(start_sel), .vdi_in(vdi_in), .hit(hit),
        .bit_stb(bit_stb), .bit_in(bit_in), .rd_stb(rd_stb),
        .sync_clr(sync_clr), .sync_shift(sync_shift), .op(op)
    );

    rbf_bit_store #(.D(DEPTH), .CW(CNT_W)) u_store (
        .clk(clk), .rst(rst), .op(op), .ovf_clr(stat_rd),
        .head_bit(rd_bit), .cnt(fill_cnt), .ovf(ovf_flag)
    );

    assign lvl_irq    = fill_cnt >= {lvl_hi, lvl_lo};
    assign empty_flag = fill_cnt == '0;

    // R9: FIFO disabled forces the count to zero
    p_off_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |=> fill_cnt == '0);
    // R8: with the arm low the count can only fall
    p_disarmed_no_growth_r8: assert property (@(posedge clk) disable iff (rst)
        (!fill_arm && fifo_on) |=> fill_cnt <= $past(fill_cnt));
endmodule

// File: tb/sim_rx_bit_fifo.sv
module sim_rx_bit_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0, bit_stb = 1'b0, vdi_in = 1'b0;
    logic       fifo_on = 1'b0, fill_arm = 1'b0;
    logic [1:0] start_sel = 2'b11;
    logic [3:0] lvl_lo = 4'd1;
    logic [1:0] lvl_hi = 2'd0;
    logic       rd_stb = 1'b0, stat_rd = 1'b0;
    logic       rd_bit;
    logic [5:0] fill_cnt;
    logic       lvl_irq, ovf_flag, empty_flag;

    int n_chk = 0, n_fail = 0, cyc = 0;

    rx_bit_fifo u0 (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb),
        .vdi_in(vdi_in), .fifo_on(fifo_on), .fill_arm(fill_arm),
        .start_sel(start_sel), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi),
        .rd_stb(rd_stb), .stat_rd(stat_rd), .rd_bit(rd_bit),
        .fill_cnt(fill_cnt), .lvl_irq(lvl_irq), .ovf_flag(ovf_flag),
        .empty_flag(empty_flag)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(logic b, logic v = 1'b0);
        @(negedge clk);
        bit_in = b; vdi_in = v; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; vdi_in = 1'b0;
    endtask

    task automatic pull(output logic b);
        @(negedge clk);
        b = rd_bit; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic rearm(logic [1:0] sel);
        @(negedge clk);
        start_sel = sel; fill_arm = 1'b0;
        @(negedge clk);
        fill_arm = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 count", fill_cnt, 0);
        chk("R1 empty", empty_flag, 1);
        chk("R1 overflow", ovf_flag, 0);
    endtask

    task automatic t_always;
        logic [7:0] pat = 8'b1011_0010;
        logic b;
        rearm(2'b11);
        for (int i = 7; i >= 0; i--) send(pat[i]);
        chk("R6 count after 8 strobes", fill_cnt, 8);
        chk("R10 not empty", empty_flag, 0);
        for (int i = 7; i >= 0; i--) begin
            pull(b);
            chk("R2 order", b, pat[i]);
        end
        chk("R2 count after reads", fill_cnt, 0);
        chk("R10 empty after drain", empty_flag, 1);
        pull(b);
        chk("R10 read on empty ignored", fill_cnt, 0);
        send(1'b1);
        chk("R10 count after read on empty", fill_cnt, 1);
        pull(b);
        chk("R10 bit after read on empty", b, 1);
    endtask

    task automatic t_vdi;
        logic b;
        rearm(2'b00);
        send(1'b1, 1'b0);
        send(1'b0, 1'b1);
        send(1'b1, 1'b0);
        send(1'b1, 1'b1);
        send(1'b0, 1'b0);
        send(1'b0, 1'b1);
        chk("R4 count with vdi gating", fill_cnt, 3);
        pull(b); chk("R4 bit0", b, 0);
        pull(b); chk("R4 bit1", b, 1);
        pull(b); chk("R4 bit2", b, 0);
    endtask

    task automatic t_sync(logic [1:0] sel);
        logic [15:0] sw = 16'h2DD4;
        logic [3:0]  tail = 4'b1001;
        logic b;
        rearm(sel);
        send(1); send(1); send(1); send(0); send(0);
        chk("R5 no write before sync", fill_cnt, 0);
        for (int i = 15; i >= 0; i--) send(sw[i]);
        chk("R5 pattern bits not stored", fill_cnt, 0);
        for (int i = 3; i >= 0; i--) send(tail[i]);
        chk("R5 bits after sync stored", fill_cnt, 4);
        for (int i = 3; i >= 0; i--) begin
            pull(b);
            chk("R5 post-sync order", b, tail[i]);
        end
        rearm(sel);
        send(1); send(0); send(1);
        chk("R8 restart resets sync search", fill_cnt, 0);
    endtask

    task automatic t_level;
        logic b;
        rearm(2'b11);
        lvl_lo = 4'd3; lvl_hi = 2'd0;
        send(1); send(0);
        chk("R7 below threshold", lvl_irq, 0);
        send(1);
        chk("R7 at threshold", lvl_irq, 1);
        pull(b);
        chk("R7 drops after read", lvl_irq, 0);
        lvl_lo = 4'd0; lvl_hi = 2'd1;
        for (int i = 0; i < 13; i++) send(1'(i));
        chk("R7 count 15", fill_cnt, 15);
        chk("R7 upper-bit threshold not met", lvl_irq, 0);
        send(1);
        chk("R7 upper-bit threshold met", lvl_irq, 1);
        rearm(2'b11);
        lvl_lo = 4'd1; lvl_hi = 2'd0;
        chk("R7 thr 1 empty", lvl_irq, 0);
        send(0);
        chk("R7 thr 1 data available", lvl_irq, 1);
    endtask

    task automatic t_overflow;
        logic b;
        rearm(2'b11);
        for (int i = 0; i < 48; i++) send(1'(i % 3 == 0));
        chk("R3 full count", fill_cnt, 48);
        chk("R3 no overflow at full", ovf_flag, 0);
        send(0);
        chk("R3 count stays 48", fill_cnt, 48);
        chk("R3 overflow set", ovf_flag, 1);
        pull(b);
        chk("R3 oldest bit survives", b, 1);
        pull(b);
        chk("R3 second bit", b, 0);
        chk("R3 overflow sticky", ovf_flag, 1);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R3 overflow cleared by status read", ovf_flag, 0);
    endtask

    task automatic t_disarm;
        rearm(2'b11);
        send(1); send(1); send(0); send(1); send(0);
        @(negedge clk); fill_arm = 1'b0;
        send(1); send(1); send(1);
        chk("R8 no write while disarmed", fill_cnt, 5);
        @(negedge clk); fill_arm = 1'b1;
        @(negedge clk);
        chk("R8 rearm empties", fill_cnt, 0);
    endtask

    task automatic t_off;
        rearm(2'b11);
        send(1); send(0); send(1);
        chk("R9 count before disable", fill_cnt, 3);
        @(negedge clk); fifo_on = 1'b0;
        @(negedge clk);
        chk("R9 disable clears count", fill_cnt, 0);
        send(1);
        chk("R9 no write while disabled", fill_cnt, 0);
        fifo_on = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        fifo_on = 1'b1;
        t_always();
        t_vdi();
        t_sync(2'b01);
        t_sync(2'b10);
        t_level();
        t_overflow();
        t_disarm();
        t_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule